// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block joins two data ports of the same width. A direction input picks which port drives the other. While it passes data, the block also handles parity. When data moves from port A to port B, the block generates a parity bit on a shared parity pin. When data moves from B to A, the same pin becomes an input. The block compares the incoming bit against the parity of the B data and reports the result on a status pin.

A select input chooses odd or even parity for both directions. An active-high disable input releases every pin the block can drive. Each three-state pin is split into three signals: an input value, an output value and an active-high drive enable. Pad cells outside the block make the physical connection. The block has no clock and no stored state, so every output follows its inputs in the same evaluation.

Top module: `pbt_xcvr`

## Requirements
- R1: With `out_dis`=0 and `dir_tx`=1 (transmit), `b_oe`=1, `b_out` equals `a_in`, and `a_oe`=0.
- R2: With `out_dis`=0 and `dir_tx`=0 (receive), `a_oe`=1, `a_out` equals `b_in`, and `b_oe`=0.
- R3: With `out_dis`=1, `a_oe`, `b_oe`, `par_oe` and `err_oe` are all 0, whatever `dir_tx` is.
- R4: In transmit, `par_oe`=1 and `par_out` = `odd_sel` XOR (number of ones in `a_in` is odd). For example, `odd_sel`=1 with an even count gives `par_out`=1. `par_in` has no effect on any output in transmit.
- R5: In transmit, `err_oe`=0.
- R6: In receive, `par_oe`=0 and `err_oe`=1. `err_out` = NOT(`par_in` XOR `odd_sel` XOR (number of ones in `b_in` is odd)). A value of 1 means the parity matched and 0 means a parity error.
- R7: `a_oe` and `b_oe` are never 1 at the same time.
- R8: Any output whose drive enable is 0 (`a_out`, `b_out`, `par_out`, `err_out`) reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1: A drives B and parity is generated; 0: B drives A and parity is checked |
| out_dis | input | 1 | 1: release every driven pin |
| odd_sel | input | 1 | Parity sense select, shared by generator and checker |
| a_in | input | DATA_W | Value seen on port A pins |
| a_out | output | DATA_W | Value to drive on port A pins |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | DATA_W | Value seen on port B pins |
| b_out | output | DATA_W | Value to drive on port B pins |
| b_oe | output | 1 | Drive enable for port B |
| par_in | input | 1 | Value seen on the parity pin |
| par_out | output | 1 | Generated parity to drive on the parity pin |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_out | output | 1 | Check result, 1 = parity good |
| err_oe | output | 1 | Drive enable for the check result pin |

## Verification
The hardest case to reach is a mismatch in the parity check. This requires an incoming parity bit that disagrees with the B data under the selected sense, while the A data, the disable input and the direction input are all set so that they hide nothing. The stimulus sweeps every data value under every combination of direction, disable, parity select and incoming parity. B is fed a scrambled copy of the value driven on A, so the two ports carry unrelated parities. As a result, every data value meets every mismatch and match case in both directions.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  typedef enum logic [1:0] {
    PBT_OFF = 2'd0,
    PBT_TX  = 2'd1,
    PBT_RX  = 2'd2
  } pbt_mode_e;

  typedef struct packed {
    logic a;
    logic b;
    logic par;
    logic err;
  } pbt_drv_t;

endpackage

// File: rtl/pbt_mode_ctrl.sv
module pbt_mode_ctrl
  import pbt_pkg::*;
(
  input  logic      dir_tx,
  input  logic      out_dis,
  output pbt_mode_e mode,
  output pbt_drv_t  drv
);

  always_comb begin
    if (out_dis)     mode = PBT_OFF;
    else if (dir_tx) mode = PBT_TX;
    else             mode = PBT_RX;
  end

  always_comb begin
    drv = '0;
    unique case (mode)
      PBT_TX: begin
        drv.b   = 1'b1;
        drv.par = 1'b1;
      end
      PBT_RX: begin
        drv.a   = 1'b1;
        drv.err = 1'b1;
      end
      default: drv = '0;
    endcase
  end

endmodule

// File: rtl/pbt_xor_tree.sv
module pbt_xor_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  output logic             odd
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [LEAVES-1:0] padded;
  logic [NODES-1:0]  node;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = data;
  end

  genvar gj;
  generate
    for (gj = 0; gj < LEAVES; gj++) begin : g_leaf
      assign node[LEAVES-1+gj] = padded[gj];
    end
    for (gj = 0; gj < LEAVES - 1; gj++) begin : g_node
      assign node[gj] = node[2*gj+1] ^ node[2*gj+2];
    end
  endgenerate

  assign odd = node[0];

endmodule

// File: rtl/pbt_xcvr.sv
module pbt_xcvr
  import pbt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              dir_tx,
  input  logic              out_dis,
  input  logic              odd_sel,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  output logic              err_out,
  output logic              err_oe
);

  pbt_mode_e mode;
  pbt_drv_t  drv;
  logic      a_odd;
  logic      b_odd;

  pbt_mode_ctrl u_ctrl (
    .dir_tx  (dir_tx),
    .out_dis (out_dis),
    .mode    (mode),
    .drv     (drv)
  );

  pbt_xor_tree #(.WIDTH(DATA_W)) u_tree_a (
    .data (a_in),
    .odd  (a_odd)
  );

  pbt_xor_tree #(.WIDTH(DATA_W)) u_tree_b (
    .data (b_in),
    .odd  (b_odd)
  );

  assign a_oe    = drv.a;
  assign b_oe    = drv.b;
  assign par_oe  = drv.par;
  assign err_oe  = drv.err;

  assign a_out   = drv.a   ? b_in : '0;
  assign b_out   = drv.b   ? a_in : '0;
  assign par_out = drv.par ? (odd_sel ^ a_odd) : 1'b0;
  assign err_out = drv.err ? ~(par_in ^ odd_sel ^ b_odd) : 1'b0;

  always_comb begin
    // R7
    a_b_excl_chk: assert (!(a_oe && b_oe));
    // R3
    float_all_chk: assert (!out_dis || !(a_oe || b_oe || par_oe || err_oe));
    // R5
    tx_err_float_chk: assert (!(dir_tx && err_oe));
    // R4
    tx_parity_chk: assert (!par_oe ||
      (par_out == (odd_sel ^ (($countones(a_in) % 2) == 1))));
    // R6
    rx_check_chk: assert (!err_oe ||
      (err_out == !(par_in ^ odd_sel ^ (($countones(b_in) % 2) == 1))));
    // R8
    quiet_a_chk: assert (a_oe || (a_out == '0));
    // R8
    quiet_b_chk: assert (b_oe || (b_out == '0));
  end

endmodule

// File: tb/pbt_xcvr_tb.sv
module pbt_xcvr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int MAX_CYC    = 200000;

  logic         clk = 1'b0;
  logic         dir_tx, out_dis, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err_out, err_oe;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbt_xcvr #(.DATA_W(W)) u_dut (
    .dir_tx (dir_tx), .out_dis (out_dis), .odd_sel (odd_sel),
    .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
    .par_in (par_in), .par_out (par_out), .par_oe (par_oe),
    .err_out (err_out), .err_oe (err_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit odd_ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  // Behavioural reference applied to the current stimulus
  task automatic check_vector();
    bit tx  = !out_dis && dir_tx;
    bit rx  = !out_dis && !dir_tx;
    bit pex = odd_sel ^ odd_ones(a_in);
    bit eex = !(par_in ^ odd_sel ^ odd_ones(b_in));
    // R1
    check("R1", "b_oe", b_oe, tx);
    check("R1", "b_out", b_out, tx ? a_in : '0);
    // R2
    check("R2", "a_oe", a_oe, rx);
    check("R2", "a_out", a_out, rx ? b_in : '0);
    // R4
    check("R4", "par_oe", par_oe, tx);
    check("R4", "par_out", par_out, tx ? pex : 1'b0);
    // R5 / R6
    check(tx ? "R5" : "R6", "err_oe", err_oe, rx);
    check("R6", "err_out", err_out, rx ? eex : 1'b0);
    // R7
    check("R7", "exclusive enables", a_oe & b_oe, 1'b0);
    // R3
    if (out_dis)
      check("R3", "any enable", {a_oe, b_oe, par_oe, err_oe}, 4'b0);
    // R8
    if (!par_oe) check("R8", "par_out idle", par_out, 1'b0);
  endtask

  initial begin
    dir_tx = 1'b1; out_dis = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
    a_in = '0; b_in = '0;
    @(negedge clk);
    // R3 idle state with everything released
    check("R3", "idle enables", {a_oe, b_oe, par_oe, err_oe}, 4'b0);
    // R8 idle outputs quiet
    check("R8", "idle outputs", {a_out, b_out, par_out, err_out}, '0);

    // Named corner cases
    @(posedge clk);
    out_dis = 1'b0; dir_tx = 1'b1; odd_sel = 1'b1; a_in = 8'h03; par_in = 1'b0;
    @(negedge clk);
    check("R4", "even count, select high", par_out, 1'b1);
    @(posedge clk);
    par_in = 1'b1;
    @(negedge clk);
    check("R4", "par_in ignored in transmit", par_out, 1'b1);
    @(posedge clk);
    dir_tx = 1'b0; odd_sel = 1'b1; par_in = 1'b1; b_in = 8'h07;
    @(negedge clk);
    check("R6", "odd count reports error", err_out, 1'b0);
    @(posedge clk);
    b_in = 8'h0F;
    @(negedge clk);
    check("R6", "even count reports good", err_out, 1'b1);

    // Exhaustive sweep
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 256; d++) begin
        @(posedge clk);
        out_dis = m[3]; dir_tx = m[2]; odd_sel = m[1]; par_in = m[0];
        a_in = W'(d);
        b_in = W'((d * 7 + 13) % 256);
        @(negedge clk);
        check_vector();
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, MAX_CYC);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule